// File: doc/BRIEF.md
# Consecutive-Service System Enable Gate

This block drives an active-low system enable line that arms critical downstream functions only once software has shown a run of healthy watchdog services. It sits beside a windowed watchdog and takes three kinds of input from it: a level that says the system reset is currently asserted, a one-cycle strobe for each clear that landed inside the open window, and a one-cycle strobe for each fault. A fault is either a clear that came too early or a window that expired without a clear. A separate supply-monitor level reports a brownout.

The gate counts good services in an unbroken run. Once the run reaches the required length, it drives the enable low and keeps it low. The enable is released, and the run is discarded, by a system reset, a brownout, a watchdog fault or a synchronous reset of the block. System reset and brownout act on the output in the same cycle, through logic with no register on the path. Faults act at the next clock edge.

Top module: `svc_enable_gate`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears its run count and `en_n` reads 1 after that edge. After `rst_n` is released, `en_n` stays 1 until a full new run of good services has been seen.
- R2: Whenever `sys_rst_act` is 1, `en_n` is 1 in that same cycle, with no clock edge needed.
- R3: Whenever `brownout` is 1, `en_n` is 1 in that same cycle, with no clock edge needed.
- R4: `en_n` goes to 0 right after the clock edge that samples the NEED_SVC-th consecutive `good_svc` strobe. NEED_SVC defaults to 3.
- R5: With fewer than NEED_SVC consecutive good services since the last clear, `en_n` stays 1.
- R6: A `bad_evt` strobe sampled at an edge clears the run count, so `en_n` is 1 after that edge. A full new run of NEED_SVC good services is then needed to arm again.
- R7: When `good_svc` and `bad_evt` are sampled in the same cycle, the fault wins and the good strobe is not counted.
- R8: A `good_svc` strobe sampled while `sys_rst_act` or `brownout` is 1 is not counted. Either level also clears the run count at that edge.
- R9: The run count saturates at NEED_SVC. Further good services keep `en_n` at 0 and never wrap the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sys_rst_act | input | 1 | Level, 1 while the system reset output is asserted |
| brownout | input | 1 | Level, 1 while the monitored supply is below threshold |
| good_svc | input | 1 | One-cycle strobe, watchdog cleared inside the open window |
| bad_evt | input | 1 | One-cycle strobe, early clear or missed service |
| en_n | output | 1 | Active-low system enable |

## Verification
The assertions assume that `good_svc` and `bad_evt` are single-cycle strobes that are synchronous to `clk`. They also assume that the two levels, `sys_rst_act` and `brownout`, only change between clock edges. The bench meets these assumptions by driving every input on the falling edge and raising each strobe for exactly one period. The one deliberate overlap is the same-cycle good-and-bad case. In that case both strobes still last a single cycle, and the fault priority is what the bench checks.

// File: rtl/svc_gate_pkg.sv
// Package: shared action encoding for the service enable gate.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package svc_gate_pkg;

    // What the run counter must do in the current cycle.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // keep the count
        ACT_STEP  = 2'd1,   // one more good service
        ACT_CLEAR = 2'd2    // discard the run
    } svc_act_e;

endpackage

// File: rtl/svc_qualifier.sv
// Module: svc_qualifier
// Turns the raw watchdog and supply inputs into one counter action and a
// force-off level. Priority order: a system reset or brownout clears first,
// a fault clears next, and a good service steps only when nothing clears.
// Assumes the strobes are single-cycle and synchronous to the block clock.
module svc_qualifier
    import svc_gate_pkg::*;
(
    input  logic     sys_rst_act,
    input  logic     brownout,
    input  logic     good_svc,
    input  logic     bad_evt,
    output svc_act_e act,
    output logic     force_off
);

    // Purpose: combine the two levels that must silence the enable at once.
    always_comb begin
        force_off = sys_rst_act | brownout;
    end

    // Purpose: pick the counter action; clearing always outranks stepping.
    always_comb begin
        if (sys_rst_act || brownout) begin
            act = ACT_CLEAR;
        end else if (bad_evt) begin
            act = ACT_CLEAR;
        end else if (good_svc) begin
            act = ACT_STEP;
        end else begin
            act = ACT_IDLE;
        end
    end

endmodule

// File: rtl/svc_run_counter.sv
// Module: svc_run_counter
// Counts consecutive good services up to NEED_SVC and saturates there.
// Registers an armed flag that is true once the count has reached NEED_SVC.
// Assumes one action per clock, as produced by svc_qualifier.
module svc_run_counter
    import svc_gate_pkg::*;
#(
    parameter int NEED_SVC = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  svc_act_e act,
    output logic     armed
);

    localparam int CW = $clog2(NEED_SVC + 1);
    localparam logic [CW-1:0] FULL = CW'(NEED_SVC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Purpose: next count from the action, saturating at FULL.
    always_comb begin
        cnt_d = cnt_q;
        unique case (act)
            ACT_CLEAR: cnt_d = '0;
            ACT_STEP:  cnt_d = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
            default:   cnt_d = cnt_q;
        endcase
    end

    // Purpose: hold the run count and the armed flag; synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            armed <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            armed <= (cnt_d == FULL);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R9

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CLEAR) |=> (cnt_q == '0) && !armed); // R6

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && cnt_q < FULL) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

    AST_ARMED_MATCHES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && cnt_q == FULL - 1'b1) |=> armed); // R4

endmodule

// File: rtl/svc_en_driver.sv
// Module: svc_en_driver
// Produces the active-low enable from the armed flag and the force-off level.
// The force-off path is combinational, so a reset or brownout silences the
// enable in the same cycle. Assumes armed comes from a register.
module svc_en_driver (
    input  logic armed,
    input  logic force_off,
    output logic en_n
);

    // Purpose: the enable is active only while armed and not forced off.
    always_comb begin
        en_n = ~(armed & ~force_off);
    end

endmodule

// File: rtl/svc_enable_gate.sv
// Module: svc_enable_gate (top)
// Active-low system enable, armed after NEED_SVC consecutive good watchdog
// services and dropped by a system reset, a brownout or a watchdog fault.
// Assumes synchronous strobes and a synchronous active-low block reset.
module svc_enable_gate
    import svc_gate_pkg::*;
#(
    parameter int NEED_SVC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst_act,
    input  logic brownout,
    input  logic good_svc,
    input  logic bad_evt,
    output logic en_n
);

    svc_act_e act;
    logic     force_off;
    logic     armed;

    svc_qualifier u_qual (
        .sys_rst_act (sys_rst_act),
        .brownout    (brownout),
        .good_svc    (good_svc),
        .bad_evt     (bad_evt),
        .act         (act),
        .force_off   (force_off)
    );

    svc_run_counter #(
        .NEED_SVC (NEED_SVC)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .armed (armed)
    );

    svc_en_driver u_drv (
        .armed     (armed),
        .force_off (force_off),
        .en_n      (en_n)
    );

    AST_HOLD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act |-> en_n); // R2

    AST_BROWN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        brownout |-> en_n); // R3

    AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_evt |=> en_n); // R6

    AST_BAD_BEATS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_evt && good_svc) |=> en_n); // R7

    AST_LEVEL_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_act || brownout) |=> en_n); // R8

endmodule

// File: tb/tb_svc_enable_gate.sv
module tb_svc_enable_gate;

    localparam int NEED = 3;

    logic clk = 1'b0;
    logic rst_n, sys_rst_act, brownout, good_svc, bad_evt;
    logic en_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    svc_enable_gate #(.NEED_SVC(NEED)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_rst_act (sys_rst_act),
        .brownout    (brownout),
        .good_svc    (good_svc),
        .bad_evt     (bad_evt),
        .en_n        (en_n)
    );

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (en_n !== exp) begin
            n_fail++;
            $display("FAIL %s: en_n actual=%b expected=%b at %0t", req, en_n, exp, $time);
        end
    endtask

    // One good strobe; returns at the falling edge after the sampling edge.
    task automatic pulse_good();
        good_svc = 1'b1;
        @(negedge clk);
        good_svc = 1'b0;
    endtask

    task automatic pulse_bad();
        bad_evt = 1'b1;
        @(negedge clk);
        bad_evt = 1'b0;
    endtask

    task automatic arm();
        for (int i = 0; i < NEED; i++) pulse_good();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sys_rst_act = 1'b0; brownout = 1'b0;
        good_svc = 1'b0; bad_evt = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b1);
    endtask

    task automatic t_arm_and_saturate();
        pulse_good(); check("R5 after 1 good", 1'b1);
        pulse_good(); check("R5 after 2 good", 1'b1);
        pulse_good(); check("R4 after 3rd good", 1'b0);
        repeat (5) pulse_good();
        check("R9 after extra goods", 1'b0);
        repeat (3) @(negedge clk);
        check("R9 holds while idle", 1'b0);
    endtask

    task automatic t_sys_reset();
        sys_rst_act = 1'b1;
        #1 check("R2 same-cycle off", 1'b1);
        @(negedge clk);
        good_svc = 1'b1;
        @(negedge clk);
        good_svc = 1'b0;
        sys_rst_act = 1'b0;
        @(negedge clk);
        check("R8 off after reset release", 1'b1);
        pulse_good(); pulse_good();
        check("R8 good in reset not counted", 1'b1);
        pulse_good();
        check("R4 rearm after reset", 1'b0);
    endtask

    task automatic t_brownout();
        brownout = 1'b1;
        #1 check("R3 same-cycle off", 1'b1);
        @(negedge clk);
        pulse_good(); pulse_good();
        brownout = 1'b0;
        @(negedge clk);
        check("R8 off after brownout", 1'b1);
        pulse_good(); pulse_good();
        check("R8 goods in brownout not counted", 1'b1);
        pulse_good();
        check("R4 rearm after brownout", 1'b0);
    endtask

    task automatic t_fault_when_armed();
        pulse_bad();
        check("R6 fault drops enable", 1'b1);
        pulse_good(); pulse_good();
        check("R6 run restarted", 1'b1);
        pulse_good();
        check("R6 rearm after fault", 1'b0);
    endtask

    task automatic t_fault_mid_run();
        pulse_bad();
        pulse_good(); pulse_good();
        pulse_bad();
        pulse_good(); pulse_good();
        check("R6 mid-run fault clears count", 1'b1);
        pulse_good();
        check("R6 full fresh run arms", 1'b0);
    endtask

    task automatic t_same_cycle();
        pulse_bad();
        pulse_good(); pulse_good();
        good_svc = 1'b1; bad_evt = 1'b1;
        @(negedge clk);
        good_svc = 1'b0; bad_evt = 1'b0;
        check("R7 fault wins", 1'b1);
        pulse_good(); pulse_good();
        check("R7 good not counted", 1'b1);
        pulse_good();
        check("R7 rearm", 1'b0);
    endtask

    task automatic t_block_reset_armed();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 block reset drops enable", 1'b1);
        rst_n = 1'b1;
        pulse_good(); pulse_good();
        check("R1 count cleared by block reset", 1'b1);
        pulse_good();
        check("R4 rearm after block reset", 1'b0);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_arm_and_saturate();
                t_sys_reset();
                t_brownout();
                t_fault_when_armed();
                t_fault_mid_run();
                t_same_cycle();
                t_block_reset_armed();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run hung, actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule